// File: doc/BRIEF.md
# I2C Bus State Monitor

This block listens passively to the clock and data lines of a two-wire serial bus and keeps a two-bit view of who holds the bus. Both lines are first brought into the local clock domain through a chain of synchronizing flops. The block then looks for start and stop conditions and reports each one as a single-cycle pulse. It never drives the bus, takes no part in arbitration and does not look at data bits.

The bus view begins as unknown after reset, because the monitor cannot tell whether it woke up in the middle of a transfer. It leaves unknown in only three ways: a stop is seen, a programmable number of cycles pass, or software forces the idle code. Once the view is known, a start makes it owner if the local master reports that its own transfer is running, and busy otherwise. A stop always brings it back to idle. The view is meant to gate a local master, which should begin a transfer only when the view is idle.

Top module: `i2c_bus_state_mon`

## Requirements
- R1: The state output uses the codes 0 = unknown, 1 = idle, 2 = owner (local master holds the bus) and 3 = busy (another master holds it). While reset is held, the state reads 0 and both pulse outputs read 0.
- R2: A start condition is the synchronized data line falling while the synchronized clock line is high. It raises `start_o` for exactly one cycle, three rising edges after the line change on the inputs.
- R3: A stop condition is the synchronized data line rising while the synchronized clock line is high. It raises `stop_o` for exactly one cycle, three rising edges after the line change.
- R4: A change of the data line while the clock line is low, and a change of the clock line alone, raise no pulse and leave the state unchanged.
- R5: A stop moves the state to idle from any state, including unknown.
- R6: A start seen while the state is idle, owner or busy moves the state to owner if `own_xfer_i` is high and to busy if it is low. This also applies to a repeated start.
- R7: A start seen while the state is unknown leaves the state unknown. The start pulse is still produced.
- R8: If the state stays unknown for `tmo_limit_i` rising edges after reset is released, it becomes idle on that edge. A limit of 0 acts like a limit of 1.
- R9: A write (`sw_wr_i` high) with `sw_state_i` = 1 sets the state to idle on the next rising edge, from any state.
- R10: A write with any code other than 1 leaves the state unchanged.
- R11: Synchronous active-low reset returns the state to unknown and clears the timeout count, so the full limit is counted again after each reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Sampled bus clock line, asynchronous |
| sda_i | input | 1 | Sampled bus data line, asynchronous |
| own_xfer_i | input | 1 | High while the local master runs its own transfer |
| sw_wr_i | input | 1 | One-cycle strobe for a software write of the state |
| sw_state_i | input | 2 | Code written with `sw_wr_i`; only the idle code 1 acts |
| tmo_limit_i | input | TMO_W | Cycles the state may stay unknown before it is forced idle |
| state_o | output | 2 | Bus state code |
| start_o | output | 1 | One-cycle pulse on a detected start |
| stop_o | output | 1 | One-cycle pulse on a detected stop |

## Verification
The assertions assume that `own_xfer_i`, `sw_wr_i`, `sw_state_i` and `tmo_limit_i` are synchronous to `clk`, and that the two bus lines never change in the same cycle. Only the second condition lets the monitor tell a start or stop apart from a clock transition. The stimulus changes one line at a time, holds each level for several cycles, and changes the limit only while reset is held. Software writes are kept apart from line events, so each check sees one cause at a time.

// File: rtl/i2c_bsm_pkg.sv
// Shared types for the bus state monitor.
// Assumes: nothing beyond a 2-bit state field.
package i2c_bsm_pkg;

    // Bus state codes; the numeric values are visible at the port.
    typedef enum logic [1:0] {
        BUS_UNKNOWN = 2'd0,
        BUS_IDLE    = 2'd1,
        BUS_OWNER   = 2'd2,
        BUS_BUSY    = 2'd3
    } bus_state_e;

endpackage

// File: rtl/bsm_line_sync.sv
// Multi-flop synchronizer for one bus line.
// Assumes: STAGES >= 2. Resets to the released (high) line level, so
// no edge is seen when reset is released on an idle bus.
module bsm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{1'b1}};
        else        chain_q <= {chain_q[STAGES-2:0], line_i};
    end

    assign line_o = chain_q[STAGES-1];

endmodule

// File: rtl/bsm_cond_detect.sv
// Start and stop detector on synchronized lines.
// Assumes: both inputs are already in the clk domain. The clock line
// must be high in both the previous and the current sample.
// Gives a same-cycle detect for the state logic and a registered pulse
// for the ports.
module bsm_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic start_q,
    output logic stop_q
);

    logic scl_prev_q;
    logic sda_prev_q;

    // Keep last synchronized line levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    // Data edge during a steady high clock marks a condition.
    always_comb begin
        start_det = scl_s && scl_prev_q && sda_prev_q && !sda_s;
        stop_det  = scl_s && scl_prev_q && !sda_prev_q && sda_s;
    end

    // Register the detects into port pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            start_q <= start_det;
            stop_q  <= stop_det;
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);                                   // R2
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> !stop_q);                                     // R3
    AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_q && stop_q));                                   // R4

endmodule

// File: rtl/bsm_state_ctrl.sv
// Bus state register with unknown-state timeout.
// Assumes: start_det/stop_det are single-cycle detects. tmo_limit is
// steady while the state is unknown. Precedence for the next state:
// software idle write, then stop, then start, then timeout.
module bsm_state_ctrl
    import i2c_bsm_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             own_xfer,
    input  logic             sw_wr,
    input  logic [1:0]       sw_code,
    input  logic [TMO_W-1:0] tmo_limit,
    output bus_state_e       state
);

    localparam int CW = TMO_W + 1;

    bus_state_e       state_q;
    bus_state_e       state_d;
    logic [TMO_W-1:0] cnt_q;
    logic             tmo_hit;
    logic             sw_idle;

    assign sw_idle = sw_wr && (sw_code == BUS_IDLE);
    assign tmo_hit = (CW'(cnt_q) + CW'(1)) >= CW'(tmo_limit);

    // Pick the next bus state by precedence.
    always_comb begin
        state_d = state_q;
        if (sw_idle)
            state_d = BUS_IDLE;
        else if (stop_det)
            state_d = BUS_IDLE;
        else if (start_det && state_q != BUS_UNKNOWN)
            state_d = own_xfer ? BUS_OWNER : BUS_BUSY;
        else if (state_q == BUS_UNKNOWN && tmo_hit)
            state_d = BUS_IDLE;
    end

    // Hold the bus state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_UNKNOWN;
        else        state_q <= state_d;
    end

    // Count cycles spent in the unknown state.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (state_q != BUS_UNKNOWN)   cnt_q <= '0;
        else if (tmo_hit)                  cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    assign state = state_q;

    AST_RESET_UNKNOWN: assert property (@(posedge clk)
        !rst_n |=> state_q == BUS_UNKNOWN);                      // R11
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state_q == BUS_IDLE);                       // R5
    AST_START_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !sw_idle && state_q != BUS_UNKNOWN && own_xfer)
        |=> state_q == BUS_OWNER);                               // R6
    AST_START_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !sw_idle && state_q != BUS_UNKNOWN && !own_xfer)
        |=> state_q == BUS_BUSY);                                // R6
    AST_START_IN_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !sw_idle && state_q == BUS_UNKNOWN)
        |=> (state_q == BUS_UNKNOWN || state_q == BUS_IDLE));    // R7
    AST_SW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_idle |=> state_q == BUS_IDLE);                        // R9
    AST_SW_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !sw_idle && !start_det && !stop_det && state_q != BUS_UNKNOWN)
        |=> $stable(state_q));                                   // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_UNKNOWN && tmo_limit != '0)
        |-> cnt_q < tmo_limit);                                  // R8

endmodule

// File: rtl/i2c_bus_state_mon.sv
// Top of the passive bus state monitor: synchronizers, condition
// detector and state register.
// Assumes: scl_i/sda_i are asynchronous samples of the open-drain lines.
// All other inputs are synchronous to clk. Reset is synchronous, active low.
module i2c_bus_state_mon
    import i2c_bsm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TMO_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             own_xfer_i,
    input  logic             sw_wr_i,
    input  logic [1:0]       sw_state_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    output logic [1:0]       state_o,
    output logic             start_o,
    output logic             stop_o
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               start_det;
    logic               stop_det;
    bus_state_e         state;

    assign raw_lines = {scl_i, sda_i};

    // One synchronizer per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        bsm_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (sync_lines[g])
        );
    end

    bsm_cond_detect i_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (sync_lines[1]),
        .sda_s     (sync_lines[0]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .start_q   (start_o),
        .stop_q    (stop_o)
    );

    bsm_state_ctrl #(.TMO_W(TMO_W)) i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .own_xfer  (own_xfer_i),
        .sw_wr     (sw_wr_i),
        .sw_code   (sw_state_i),
        .tmo_limit (tmo_limit_i),
        .state     (state)
    );

    assign state_o = state;

    AST_PULSE_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> state_o == 2'd1 || $past(sw_wr_i));           // R5
    AST_RESET_OUTPUTS: assert property (@(posedge clk)
        !rst_n |=> (state_o == 2'd0 && !start_o && !stop_o));    // R1

endmodule

// File: tb/test_i2c_bus_state_mon.sv
module test_i2c_bus_state_mon;

    localparam int TMO_W = 16;
    localparam logic [1:0] S_UNK = 2'd0, S_IDLE = 2'd1, S_OWN = 2'd2, S_BUSY = 2'd3;

    typedef struct {
        int         cyc;
        logic [1:0] st;
        logic       sta;
        logic       sto;
        string      req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl = 1'b1, sda = 1'b1;
    logic             own = 1'b0;
    logic             sw_wr = 1'b0;
    logic [1:0]       sw_code = 2'd0;
    logic [TMO_W-1:0] limit = 16'd1000;
    logic [1:0]       state_o;
    logic             start_o, stop_o;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    i2c_bus_state_mon #(.TMO_W(TMO_W)) i_i2c_bus_state_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda),
        .own_xfer_i  (own),
        .sw_wr_i     (sw_wr),
        .sw_state_i  (sw_code),
        .tmo_limit_i (limit),
        .state_o     (state_o),
        .start_o     (start_o),
        .stop_o      (stop_o)
    );

    // Monitor: pop expectations that fall due and compare.
    always @(negedge clk) begin : mon
        exp_t e;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            e = q.pop_front();
            n_chk++;
            if (e.cyc != cyc || state_o !== e.st || start_o !== e.sta || stop_o !== e.sto) begin
                n_fail++;
                $display("FAIL %s cyc %0d: state=%0d start=%0b stop=%0b, expected state=%0d start=%0b stop=%0b",
                         e.req, cyc, state_o, start_o, stop_o, e.st, e.sta, e.sto);
            end
        end
    end

    task automatic expect_at(int ofs, logic [1:0] st, logic sta, logic sto, string req);
        exp_t e;
        e.cyc = cyc + ofs; e.st = st; e.sta = sta; e.sto = sto; e.req = req;
        q.push_back(e);
    endtask

    // Change the lines; outputs react three edges later, pulse gone one edge after.
    task automatic lines(logic c, logic d, logic [1:0] st, logic sta, logic sto, string req);
        @(negedge clk);
        scl = c; sda = d;
        expect_at(3, st, sta, sto, req);
        expect_at(4, st, 1'b0, 1'b0, req);
        repeat (5) @(negedge clk);
    endtask

    task automatic sw_write(logic [1:0] code, logic [1:0] st, string req);
        @(negedge clk);
        sw_wr = 1'b1; sw_code = code;
        expect_at(1, st, 1'b0, 1'b0, req);
        @(negedge clk);
        sw_wr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset(logic [TMO_W-1:0] lim);
        @(negedge clk);
        rst_n = 1'b0;
        expect_at(1, S_UNK, 1'b0, 1'b0, "R1");
        repeat (3) @(negedge clk);
        limit = lim;
        rst_n = 1'b1;
    endtask

    initial begin : drive
        do_reset(16'd1000);
        expect_at(1, S_UNK, 1'b0, 1'b0, "R1");
        repeat (3) @(negedge clk);
        // start while unknown
        lines(1'b1, 1'b0, S_UNK, 1'b1, 1'b0, "R7");
        lines(1'b0, 1'b0, S_UNK, 1'b0, 1'b0, "R4");
        lines(1'b1, 1'b0, S_UNK, 1'b0, 1'b0, "R4");
        // stop resolves unknown
        lines(1'b1, 1'b1, S_IDLE, 1'b0, 1'b1, "R3,R5");
        // own start
        own = 1'b1;
        lines(1'b1, 1'b0, S_OWN, 1'b1, 1'b0, "R2,R6");
        own = 1'b0;
        lines(1'b0, 1'b0, S_OWN, 1'b0, 1'b0, "R4");
        lines(1'b0, 1'b1, S_OWN, 1'b0, 1'b0, "R4");
        lines(1'b1, 1'b1, S_OWN, 1'b0, 1'b0, "R4");
        // repeated start by another master
        lines(1'b1, 1'b0, S_BUSY, 1'b1, 1'b0, "R2,R6");
        // writes of non-idle codes
        sw_write(2'd2, S_BUSY, "R10");
        sw_write(2'd0, S_BUSY, "R10");
        sw_write(2'd3, S_BUSY, "R10");
        // forced idle
        sw_write(2'd1, S_IDLE, "R9");
        lines(1'b0, 1'b0, S_IDLE, 1'b0, 1'b0, "R4");
        lines(1'b1, 1'b0, S_IDLE, 1'b0, 1'b0, "R4");
        lines(1'b1, 1'b1, S_IDLE, 1'b0, 1'b1, "R3,R5");
        // start then stop from busy
        lines(1'b1, 1'b0, S_BUSY, 1'b1, 1'b0, "R6");
        lines(1'b0, 1'b0, S_BUSY, 1'b0, 1'b0, "R4");
        lines(1'b1, 1'b0, S_BUSY, 1'b0, 1'b0, "R4");
        lines(1'b1, 1'b1, S_IDLE, 1'b0, 1'b1, "R5");
        // timeout with limit 5
        do_reset(16'd5);
        expect_at(4, S_UNK, 1'b0, 1'b0, "R8");
        expect_at(5, S_IDLE, 1'b0, 1'b0, "R8");
        repeat (8) @(negedge clk);
        // reset mid-count restarts the full count
        do_reset(16'd5);
        repeat (3) @(negedge clk);
        do_reset(16'd5);
        expect_at(4, S_UNK, 1'b0, 1'b0, "R11");
        expect_at(5, S_IDLE, 1'b0, 1'b0, "R11");
        repeat (8) @(negedge clk);
        // limit 0 acts as 1
        do_reset(16'd0);
        expect_at(1, S_IDLE, 1'b0, 1'b0, "R8");
        repeat (4) @(negedge clk);
        // forced idle out of unknown
        do_reset(16'd1000);
        repeat (2) @(negedge clk);
        sw_write(2'd1, S_IDLE, "R9");
        repeat (10) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule